// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

A serial transmit engine that puts a one-word holding buffer in front of a frame shift register. The bus side writes a word into the buffer. The engine moves that word into the shift register at the next bit-period boundary and sends a frame on the serial line. A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. Because of the buffer, software can queue the next word while the current one is still shifting out. A word that is already pending at the end of the last stop bit starts at once, with no idle gap.

The bit period comes from a reload value n: one bit lasts 16(n+1) cycles in which the count-enable input is high. An optional clear-to-send input, which is active low, is looked at only when a frame would start. If it blocks, the bit clock freezes and the word waits in the buffer. As soon as the input allows transfer, the start bit goes out on the following cycle, without waiting for a bit-period boundary.

Two status flags report the state of the path: one for the buffer and one for the whole transmitter. An interrupt flag is raised on one of two events, chosen by a select input: the buffer becoming empty, or the transmission completing. The flag stays set until it is acknowledged.

Top module: `uart_tx_dbuf`

## Requirements
- R1: One bit period lasts exactly 16(n+1) cycles in which clk_en_i is high, where n is baud_n_i. Cycles with clk_en_i low do not advance the bit timing.
- R2: A frame is a low start bit, then the data bits LSB first, then the parity bit when enabled, then the stop bits at 1. While no frame is sending, txd_o is 1.
- R3: data_len_i selects the number of data bits: 2'b00 sends wr_data_i[6:0], 2'b01 sends wr_data_i[7:0], and 2'b10 or 2'b11 sends all of wr_data_i[8:0].
- R4: When par_en_i is 1, a parity bit follows the last data bit. With par_odd_i=0 it is the XOR of the sent data bits (even parity). With par_odd_i=1 it is the inverse of that XOR (odd parity).
- R5: stop2_i=0 sends one stop bit; stop2_i=1 sends two.
- R6: A write pulse (wr_i=1) stores wr_data_i and drives buf_empty_o to 0 on the next cycle. buf_empty_o returns to 1 in the same cycle that the word enters the shift register and the start bit appears. An idle engine takes a buffered word at the next bit-period boundary. A second write before that boundary replaces the unsent word.
- R7: tx_empty_o is 0 while a frame is shifting or a word is pending. It becomes 1 in the first cycle after the last stop bit ends with nothing pending.
- R8: A word that is buffered before the last stop bit ends starts its start bit in the very next bit period, with no idle time.
- R9: With cts_en_i=1, cts_ni is examined only where a frame would start. If cts_ni is 1 there, no frame starts, txd_o stays 1 and the word stays pending. A change of cts_ni during a frame does not affect that frame.
- R10: A frame held back by cts_ni=1 starts as soon as cts_ni is 0: txd_o is 0 in the cycle after the first clock edge that samples cts_ni=0.
- R11: With irq_sel_i=0, irq_o is set when a word moves from the buffer to the shift register. With irq_sel_i=1, irq_o is set when a frame completes with nothing pending, and not when the buffer empties.
- R12: irq_o stays 1 until irq_ack_i is 1 at a clock edge. If a set event and an acknowledge come in the same cycle, the set wins.
- R13: With tx_en_i=0, any frame in progress is dropped, txd_o is 1 from the next cycle, and the bit timing is reset. A buffered word is kept and is sent once tx_en_i returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Count enable for the bit-period divider |
| tx_en_i | input | 1 | Transmit enable |
| wr_i | input | 1 | Write pulse into the holding buffer |
| wr_data_i | input | 9 | Word to transmit |
| data_len_i | input | 2 | Data length: 00 = 7, 01 = 8, 1x = 9 bits |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | Parity sense: 0 = even, 1 = odd |
| stop2_i | input | 1 | 0 = one stop bit, 1 = two stop bits |
| baud_n_i | input | N_W | Divider reload value n |
| cts_en_i | input | 1 | Clear-to-send gating enable |
| cts_ni | input | 1 | Clear to send, active low |
| irq_sel_i | input | 1 | Interrupt source: 0 = buffer empty, 1 = transmission complete |
| irq_ack_i | input | 1 | Interrupt acknowledge / clear |
| txd_o | output | 1 | Serial data line |
| buf_empty_o | output | 1 | Holding buffer empty |
| tx_empty_o | output | 1 | Shift register idle and nothing pending |
| irq_o | output | 1 | Latched interrupt request |

## Verification
The assertions assume that wr_i and irq_ack_i are single-cycle pulses. They also assume that data_len_i, par_en_i, par_odd_i, stop2_i and baud_n_i change only while tx_empty_o is 1. The stimulus respects this: the random part changes the mode and the divider value only after the previous frame has been seen to finish. The clear-to-send input and the transmit enable are moved at arbitrary points, including the middle of a frame, because the block has to tolerate that.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = 13;  // start + 9 data + parity + 2 stop
  localparam int LEN_W   = 4;

  function automatic logic [LEN_W-1:0] data_bits(input logic [1:0] len);
    case (len)
      2'b00:   return 4'd7;
      2'b01:   return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  // bits on the line, LSB first; unused upper positions are ones
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                     input logic [1:0] len,
                                                     input logic pe, input logic po);
    logic [9:0] body;
    logic p7, p8, p9;
    p7 = po ^ (^d[6:0]);
    p8 = po ^ (^d[7:0]);
    p9 = po ^ (^d);
    case (len)
      2'b00:   body = {2'b11, (pe ? p7 : 1'b1), d[6:0]};
      2'b01:   body = {1'b1, (pe ? p8 : 1'b1), d[7:0]};
      default: body = {(pe ? p9 : 1'b1), d};
    endcase
    return {2'b11, body, 1'b0};
  endfunction

  function automatic logic [LEN_W-1:0] frame_bits(input logic [1:0] len, input logic pe,
                                                  input logic s2);
    return 4'd2 + data_bits(len) + {3'b000, pe} + {3'b000, s2};
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int N_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           clk_en_i,
  input  logic [N_W-1:0] n_i,
  output logic           tick_o
);
  localparam int CNT_W = N_W + 4;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit  = {n_i, 4'hF};  // 16(n+1)-1
  assign tick_o = run_i && clk_en_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else if (clk_en_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift import uart_tx_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_en_i,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               txd_o,
  output logic               busy_o,
  output logic               last_o
);
  logic [FRAME_W-1:0] sr_q;
  logic [LEN_W-1:0]   left_q;
  logic               busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (!tx_en_i) begin
      sr_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= frame_i;
      left_q <= len_i - 4'd1;
      busy_q <= 1'b1;
    end else if (tick_i && busy_q) begin
      if (left_q == '0) begin
        busy_q <= 1'b0;
        sr_q   <= '1;
      end else begin
        sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
        left_q <= left_q - 4'd1;
      end
    end
  end

  assign txd_o  = sr_q[0];
  assign busy_o = busy_q;
  assign last_o = busy_q && (left_q == '0);
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf import uart_tx_pkg::*; #(
  parameter int N_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              tx_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        data_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  input  logic [N_W-1:0]    baud_n_i,
  input  logic              cts_en_i,
  input  logic              cts_ni,
  input  logic              irq_sel_i,
  input  logic              irq_ack_i,
  output logic              txd_o,
  output logic              buf_empty_o,
  output logic              tx_empty_o,
  output logic              irq_o
);
  logic              buf_full_q, hold_q, irq_q;
  logic [DATA_W-1:0] buf_q;
  logic              tick, busy, last, boundary, cts_ok, load, done_evt, irq_set;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   flen;

  assign cts_ok   = !cts_en_i || !cts_ni;
  assign boundary = tick && (!busy || last);
  // held frame starts the moment clear-to-send allows it
  assign load     = tx_en_i && buf_full_q && (hold_q ? cts_ok : (boundary && cts_ok));
  assign done_evt = boundary && busy && !buf_full_q;
  assign irq_set  = irq_sel_i ? done_evt : load;
  assign frame    = build_frame(buf_q, data_len_i, par_en_i, par_odd_i);
  assign flen     = frame_bits(data_len_i, par_en_i, stop2_i);

  uart_tx_baud #(.N_W(N_W)) i_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (tx_en_i && !hold_q),
    .clk_en_i (clk_en_i),
    .n_i      (baud_n_i),
    .tick_o   (tick)
  );

  uart_tx_shift i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tx_en_i (tx_en_i),
    .tick_i  (tick),
    .load_i  (load),
    .frame_i (frame),
    .len_i   (flen),
    .txd_o   (txd_o),
    .busy_o  (busy),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_full_q <= 1'b0;
      buf_q      <= '0;
    end else if (wr_i) begin
      buf_full_q <= 1'b1;
      buf_q      <= wr_data_i;
    end else if (load) begin
      buf_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    hold_q <= 1'b0;
    else if (!tx_en_i || load)                      hold_q <= 1'b0;
    else if (boundary && buf_full_q && !cts_ok)     hold_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (irq_set)   irq_q <= 1'b1;
    else if (irq_ack_i) irq_q <= 1'b0;
  end

  assign buf_empty_o = !buf_full_q;
  assign tx_empty_o  = !busy && !buf_full_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic tx_en_i,
  input logic cts_en_i,
  input logic cts_ni,
  input logic irq_ack_i,
  input logic txd_o,
  input logic buf_empty_o,
  input logic tx_empty_o,
  input logic irq_o
);
  AST_WR_FILLS_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !buf_empty_o); // R6

  AST_EMPTY_MEANS_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_empty_o) |-> !tx_empty_o); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o); // R12

  AST_CTS_BLOCKS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_en_i && cts_ni && tx_empty_o) |=> txd_o); // R9

  AST_DISABLE_IDLES_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> txd_o); // R13
endmodule

bind uart_tx_dbuf uart_tx_chk i_chk (.*);

// File: tb/test_uart_tx_dbuf.sv
module test_uart_tx_dbuf;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1;
  logic       half = 1'b0;
  logic       tx_en = 1'b1;
  logic       wr = 1'b0;
  logic [8:0] wr_data = '0;
  logic [1:0] data_len = 2'b01;
  logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic [7:0] baud_n = '0;
  logic       cts_en = 1'b0, cts_n = 1'b0;
  logic       irq_sel = 1'b0, irq_ack = 1'b0;
  logic       txd, buf_empty, tx_empty, irq;

  int checks = 0;
  int errors = 0;

  uart_tx_dbuf i_uart_tx_dbuf (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .tx_en_i(tx_en),
    .wr_i(wr), .wr_data_i(wr_data), .data_len_i(data_len), .par_en_i(par_en),
    .par_odd_i(par_odd), .stop2_i(stop2), .baud_n_i(baud_n), .cts_en_i(cts_en),
    .cts_ni(cts_n), .irq_sel_i(irq_sel), .irq_ack_i(irq_ack), .txd_o(txd),
    .buf_empty_o(buf_empty), .tx_empty_o(tx_empty), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) clk_en <= half ? ~clk_en : 1'b1;

  function automatic int len_of(input logic [1:0] code);
    return (code == 2'b00) ? 7 : (code == 2'b01) ? 8 : 9;
  endfunction

  function automatic int nbits_of(input logic [1:0] code, input logic pe, input logic s2);
    return 1 + len_of(code) + (pe ? 1 : 0) + (s2 ? 2 : 1);
  endfunction

  function automatic logic [12:0] exp_frame(input logic [8:0] d, input logic [1:0] code,
                                            input logic pe, input logic po);
    logic [12:0] f;
    logic p;
    int dl;
    dl = len_of(code);
    f = '1;
    f[0] = 1'b0;
    p = po;
    for (int i = 0; i < dl; i++) begin
      f[1+i] = d[i];
      p = p ^ d[i];
    end
    if (pe) f[1+dl] = p;
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] d);
    @(negedge clk);
    wr = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_loaded();
    int w = 0;
    while (buf_empty !== 1'b1 && w < 20000) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  // called at a negedge; end_mode 0 idle after, 1 next frame starts, 2 next frame held
  task automatic capture(input logic [8:0] d, input int per, input int end_mode,
                         input string req);
    logic [12:0] f;
    int nb;
    int w = 0;
    f = exp_frame(d, data_len, par_en, par_odd);
    nb = nbits_of(data_len, par_en, stop2);
    while (txd !== 1'b0 && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk(w < 20000, {req, " start bit seen"}, w, 0);
    for (int b = 0; b < nb; b++) begin
      repeat ((b == 0) ? per / 2 : per) @(negedge clk);
      chk(txd === f[b], $sformatf("%s frame bit %0d", req, b), int'(txd), int'(f[b]));
    end
    repeat (per - per / 2 - 1) @(negedge clk);
    chk(tx_empty === 1'b0 && txd === 1'b1, {req, " R7 busy in last stop bit"},
        int'(tx_empty), 0);
    @(negedge clk);
    case (end_mode)
      0: chk(tx_empty === 1'b1 && txd === 1'b1, {req, " R7 empty after last stop (R1 period)"},
             int'(tx_empty), 1);
      1: chk(txd === 1'b0 && tx_empty === 1'b0, {req, " R8 next start without gap"},
             int'(txd), 0);
      default: chk(txd === 1'b1 && tx_empty === 1'b0, {req, " R9 next frame held"},
                   int'(txd), 1);
    endcase
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    logic [8:0] d;
    int per;
    bit line_ok;
    seed_init = $urandom(32'd20240611);

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R2 reset line idle high", int'(txd), 1);
    chk(buf_empty === 1'b1, "R6 reset buffer empty", int'(buf_empty), 1);
    chk(tx_empty === 1'b1, "R7 reset transmitter empty", int'(tx_empty), 1);
    chk(irq === 1'b0, "R12 reset irq clear", int'(irq), 0);

    // R6 R11: buffer-empty interrupt source, 8N1, n=0
    do_write(9'h0A5);
    chk(buf_empty === 1'b0, "R6 write fills buffer", int'(buf_empty), 0);
    chk(tx_empty === 1'b0, "R7 pending word clears tx_empty", int'(tx_empty), 0);
    wait_loaded();
    chk(irq === 1'b1, "R11 irq on buffer transfer", int'(irq), 1);
    chk(txd === 1'b0, "R6 start bit with buffer transfer", int'(txd), 0);
    capture(9'h0A5, 16, 0, "R2");
    chk(irq === 1'b1, "R12 irq held until ack", int'(irq), 1);
    pulse_ack();
    chk(irq === 1'b0, "R12 ack clears irq", int'(irq), 0);

    // R11: completion source
    irq_sel = 1'b1;
    do_write(9'h03C);
    wait_loaded();
    chk(irq === 1'b0, "R11 no irq on buffer empty when completion selected", int'(irq), 0);
    capture(9'h03C, 16, 0, "R11");
    chk(irq === 1'b1, "R11 irq on transmission complete", int'(irq), 1);
    pulse_ack();
    irq_sel = 1'b0;

    // R8: back-to-back words, 7 data bits, odd parity, two stops
    data_len = 2'b00; par_en = 1'b1; par_odd = 1'b1; stop2 = 1'b1;
    do_write(9'h055);
    wait_loaded();
    fork
      capture(9'h055, 16, 1, "R8 R3 R4 R5 first");
      begin
        @(negedge clk);
        do_write(9'h1CB);
      end
    join
    capture(9'h1CB, 16, 0, "R8 R3 R4 R5 second");

    // random frames: R3 R4 R5 R2 R1
    for (int it = 0; it < 24; it++) begin
      @(negedge clk);
      data_len = 2'($urandom_range(0, 3));
      par_en   = 1'($urandom_range(0, 1));
      par_odd  = 1'($urandom_range(0, 1));
      stop2    = 1'($urandom_range(0, 1));
      baud_n   = 8'($urandom_range(0, 3));
      cts_en   = 1'($urandom_range(0, 1));
      cts_n    = 1'b0;
      per = 16 * (int'(baud_n) + 1);
      d = 9'($urandom_range(0, 511));
      do_write(d);
      capture(d, per, 0, $sformatf("R3 R4 R5 random %0d", it));
    end

    // R9 R10 R6: word held by clear-to-send, overwritten before release
    @(negedge clk);
    baud_n = 8'd0; data_len = 2'b01; par_en = 1'b0; stop2 = 1'b0;
    cts_en = 1'b1; cts_n = 1'b1;
    do_write(9'h011);
    do_write(9'h022);
    line_ok = 1'b1;
    repeat (100) begin
      @(negedge clk);
      if (txd !== 1'b1 || tx_empty !== 1'b0) line_ok = 1'b0;
    end
    chk(line_ok, "R9 blocked frame does not start", int'(line_ok), 1);
    cts_n = 1'b0;
    @(negedge clk);
    chk(txd === 1'b0, "R10 start right after release", int'(txd), 0);
    capture(9'h022, 16, 0, "R6 overwrite sends newer word");

    // R9: mid-frame change ignored, next word held, then released
    do_write(9'h05A);
    wait_loaded();
    fork
      capture(9'h05A, 16, 2, "R9 mid-frame cts ignored");
      begin
        repeat (3) @(negedge clk);
        do_write(9'h06B);
        repeat (20) @(negedge clk);
        cts_n = 1'b1;
      end
    join
    line_ok = 1'b1;
    repeat (50) begin
      @(negedge clk);
      if (txd !== 1'b1) line_ok = 1'b0;
    end
    chk(line_ok, "R9 held at frame boundary", int'(line_ok), 1);
    cts_n = 1'b0;
    @(negedge clk);
    chk(txd === 1'b0, "R10 held word starts at once", int'(txd), 0);
    capture(9'h06B, 16, 0, "R10");
    cts_en = 1'b0;

    // R13: disable mid-frame, buffer kept across disable
    do_write(9'h000);
    wait_loaded();
    repeat (30) @(negedge clk);
    chk(txd === 1'b0, "R13 frame running before disable", int'(txd), 0);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R13 line high after disable", int'(txd), 1);
    chk(tx_empty === 1'b1, "R13 frame dropped", int'(tx_empty), 1);
    do_write(9'h00F);
    line_ok = 1'b1;
    repeat (100) begin
      @(negedge clk);
      if (txd !== 1'b1) line_ok = 1'b0;
    end
    chk(line_ok, "R13 no start while disabled", int'(line_ok), 1);
    chk(buf_empty === 1'b0, "R13 buffered word kept", int'(buf_empty), 0);
    tx_en = 1'b1;
    capture(9'h00F, 16, 0, "R13 kept word sent");

    // R1: count enable at half rate doubles the bit period, n=1
    @(negedge clk);
    baud_n = 8'd1;
    half = 1'b1;
    do_write(9'h096);
    capture(9'h096, 64, 0, "R1 half-rate enable");
    half = 1'b0;

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule